// File: doc/BRIEF.md
# Two-Wire Potentiometer Command Slave

This block is a two-wire serial bus slave for a digitally controlled potentiometer. It runs on a fast system clock and oversamples the bus clock and data lines. It finds start and stop conditions, checks the address byte against a fixed type nibble and three strap pins, and decodes the instruction byte. It then runs the bytes that follow and answers with an open-drain data output: `sda_oe_o` high means the pin is pulled low.

Toward a register bank, the block issues at most one command per bus transaction. A command reads or writes the wiper register, reads or writes one of four data registers, or moves a value between a data register and the wiper. Commands leave through a valid/ready port. Once `cmd_valid_o` rises, the op, select and data fields hold steady until the cycle in which `cmd_ready_i` is high. While a command waits there, new addresses get no acknowledge. The bank must answer a read command by pulsing `rsp_valid_i` with the value within 8 system clocks of accepting it; the block has no ready on that response. A busy input from the bank blocks address acknowledge while a nonvolatile store runs, so a master can poll for completion.

The system clock must run at least 20 times the bus clock rate. The address and busy inputs are expected to be static during a byte.

Top module: `potctl_twowire_slave`

## Requirements
- R1: A transaction begins only at a start (data falls while the bus clock is high). Bytes clocked without a preceding start are never acknowledged. A stop is data rising while the clock is high.
- R2: The slave acknowledges (drives the data line low during the ninth clock) an address byte, MSB first, only when its upper nibble is 0101 and bits 3..1 equal `dev_addr_i`. Bit 0 is R/W (1 = read). Any other address gets no acknowledge and produces no command.
- R3: While `busy_i` is high, or while a command waits on the command port, the address byte gets no acknowledge.
- R4: The instruction byte holds the opcode in bits 7..5, a register select in bits 3..2 (00 = data register 0 ... 11 = data register 3), and zeros in bits 4, 1 and 0. With R/W=1, opcodes 100/101/110 are read-wiper, read-data and data-to-wiper transfer. With R/W=0, opcodes 101/110/111 are write-wiper, write-data and wiper-to-data transfer. Any other combination, or a nonzero reserved bit, is not acknowledged and yields no command.
- R5: A write takes two further bytes, each acknowledged. The first carries value bits 9..8 in its bits 1..0; the second carries bits 7..0. The write command with that value is issued only after the stop.
- R6: A write that ends at a stop before its second data byte, or that is cut by a new start, issues no command.
- R7: The two transfers end after the instruction byte and issue their command, with the register select, at the stop.
- R8: A read issues its command once the instruction byte is accepted. The slave then sends the response as two bytes, MSB first: six zeros followed by bits 9..8, then bits 7..0.
- R9: If the master does not acknowledge the first read byte, the slave releases the line for the rest of the transaction.
- R10: Command op codes are 0 read-wiper, 1 read-data, 2 data-to-wiper, 3 write-wiper, 4 write-data and 5 wiper-to-data. A pending command keeps `cmd_valid_o` and all its fields stable until accepted.
- R11: `sda_oe_o` changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr_i | input | 3 | Strap address compared with address bits 3..1 |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | High pulls the data line low |
| busy_i | input | 1 | Register bank store in progress |
| cmd_valid_o | output | 1 | Command waiting |
| cmd_ready_i | input | 1 | Bank takes the command this cycle |
| cmd_op_o | output | 3 | Command op code |
| cmd_sel_o | output | 2 | Data register select |
| cmd_data_o | output | 10 | Write value |
| rsp_valid_i | input | 1 | Read response strobe |
| rsp_data_i | input | 10 | Read response value |

## Verification
A wrong bit counter or a wrong byte index shows on the bus within one byte time: an acknowledge lands on the wrong clock or goes missing, or a read byte comes out shifted. A wrongly kept armed flag shows at the command port a few system clocks after the stop, as an extra or missing command, or one with the wrong op or value. A stale pending flag shows as a refused address on the next transaction.

// File: rtl/potctl_pkg.sv
package potctl_pkg;

  typedef enum logic [2:0] {
    CMD_RD_WIPER = 3'd0,
    CMD_RD_DATA  = 3'd1,
    CMD_XFER_D2W = 3'd2,
    CMD_WR_WIPER = 3'd3,
    CMD_WR_DATA  = 3'd4,
    CMD_XFER_W2D = 3'd5,
    CMD_NONE     = 3'd7
  } cmd_op_e;

  localparam logic [3:0] DEV_TYPE = 4'b0101;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic    ok;
    cmd_op_e op;
    logic    is_read;
    logic    has_data;
  } instr_dec_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACKSET, S_ACK, S_TX, S_MACK, S_WAIT
  } link_st_e;

endpackage

// File: rtl/potctl_line_sync.sv
module potctl_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;

  // R1
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  // R1
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise_o || scl_fall_o) |-> !(start_o || stop_o));

endmodule

// File: rtl/potctl_decode.sv
module potctl_decode
  import potctl_pkg::*;
(
  input  logic       rw_i,
  input  logic [7:0] instr_i,
  output instr_dec_t dec_o
);
  always_comb begin
    dec_o.ok       = 1'b0;
    dec_o.op       = CMD_NONE;
    dec_o.is_read  = 1'b0;
    dec_o.has_data = 1'b0;
    if (!instr_i[4] && instr_i[1:0] == 2'b00) begin
      case ({rw_i, instr_i[7:5]})
        4'b1100: begin dec_o.ok = 1'b1; dec_o.op = CMD_RD_WIPER; dec_o.is_read = 1'b1; dec_o.has_data = 1'b1; end
        4'b1101: begin dec_o.ok = 1'b1; dec_o.op = CMD_RD_DATA;  dec_o.is_read = 1'b1; dec_o.has_data = 1'b1; end
        4'b1110: begin dec_o.ok = 1'b1; dec_o.op = CMD_XFER_D2W; end
        4'b0101: begin dec_o.ok = 1'b1; dec_o.op = CMD_WR_WIPER; dec_o.has_data = 1'b1; end
        4'b0110: begin dec_o.ok = 1'b1; dec_o.op = CMD_WR_DATA;  dec_o.has_data = 1'b1; end
        4'b0111: begin dec_o.ok = 1'b1; dec_o.op = CMD_XFER_W2D; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/potctl_link.sv
module potctl_link
  import potctl_pkg::*;
#(
  parameter int unsigned VAL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s_i,
  input  logic             sda_s_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [2:0]       dev_addr_i,
  input  logic             hold_i,
  input  logic             rsp_valid_i,
  input  logic [VAL_W-1:0] rsp_data_i,
  output logic             sda_oe_o,
  output logic             issue_o,
  output cmd_op_e          issue_op_o,
  output logic [1:0]       issue_sel_o,
  output logic [VAL_W-1:0] issue_data_o
);
  localparam int unsigned HI_W  = VAL_W - BYTE_W;
  localparam int unsigned PAD_W = BYTE_W - HI_W;

  link_st_e         st, nxt;
  logic [2:0]       bcnt;
  logic [6:0]       sh;
  logic [1:0]       bidx;
  logic             rw, do_ack, armed, mack;
  logic [1:0]       sel;
  cmd_op_e          op;
  logic [VAL_W-1:0] wval, rval;
  logic [7:0]       txsh;
  logic [7:0]       byte_in, first_tx;
  instr_dec_t       dec;

  assign byte_in  = {sh, sda_s_i};
  assign first_tx = {{PAD_W{1'b0}}, rval[VAL_W-1:BYTE_W]};

  potctl_decode u_dec (.rw_i(rw), .instr_i(byte_in), .dec_o(dec));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rval <= '0;
    else if (rsp_valid_i) rval <= rsp_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      nxt          <= S_IDLE;
      bcnt         <= '0;
      sh           <= '0;
      bidx         <= '0;
      rw           <= 1'b0;
      do_ack       <= 1'b0;
      armed        <= 1'b0;
      mack         <= 1'b0;
      sel          <= '0;
      op           <= CMD_NONE;
      wval         <= '0;
      txsh         <= '0;
      sda_oe_o     <= 1'b0;
      issue_o      <= 1'b0;
      issue_op_o   <= CMD_NONE;
      issue_sel_o  <= '0;
      issue_data_o <= '0;
    end else begin
      issue_o <= 1'b0;
      if (start_i) begin
        st       <= S_RX;
        bcnt     <= '0;
        bidx     <= '0;
        armed    <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        if (armed) begin
          issue_o      <= 1'b1;
          issue_op_o   <= op;
          issue_sel_o  <= sel;
          issue_data_o <= wval;
        end
        armed    <= 1'b0;
        st       <= S_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        case (st)
          S_RX: if (scl_rise_i) begin
            sh   <= byte_in[6:0];
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              st <= S_ACKSET;
              case (bidx)
                2'd0: begin
                  rw     <= byte_in[0];
                  do_ack <= (byte_in[7:4] == DEV_TYPE) && (byte_in[3:1] == dev_addr_i) && !hold_i;
                  nxt    <= S_RX;
                  bidx   <= 2'd1;
                end
                2'd1: begin
                  do_ack <= dec.ok;
                  op     <= dec.op;
                  sel    <= byte_in[3:2];
                  bidx   <= 2'd2;
                  if (dec.is_read) begin
                    issue_o      <= dec.ok;
                    issue_op_o   <= dec.op;
                    issue_sel_o  <= byte_in[3:2];
                    issue_data_o <= '0;
                    nxt          <= S_TX;
                  end else if (dec.has_data) begin
                    nxt <= S_RX;
                  end else begin
                    armed <= dec.ok;
                    nxt   <= S_WAIT;
                  end
                end
                2'd2: begin
                  wval[VAL_W-1:BYTE_W] <= byte_in[HI_W-1:0];
                  do_ack <= 1'b1;
                  nxt    <= S_RX;
                  bidx   <= 2'd3;
                end
                default: begin
                  wval[BYTE_W-1:0] <= byte_in;
                  do_ack <= 1'b1;
                  armed  <= 1'b1;
                  nxt    <= S_WAIT;
                end
              endcase
            end
          end
          S_ACKSET: if (scl_fall_i) begin
            if (do_ack) begin
              sda_oe_o <= 1'b1;
              st       <= S_ACK;
            end else begin
              st <= S_IDLE;
            end
          end
          S_ACK: if (scl_fall_i) begin
            bcnt <= '0;
            if (nxt == S_TX) begin
              txsh     <= first_tx;
              sda_oe_o <= ~first_tx[7];
            end else begin
              sda_oe_o <= 1'b0;
            end
            st <= nxt;
          end
          S_TX: if (scl_fall_i) begin
            if (bcnt == 3'd7) begin
              sda_oe_o <= 1'b0;
              st       <= S_MACK;
            end else begin
              bcnt     <= bcnt + 3'd1;
              txsh     <= {txsh[6:0], 1'b0};
              sda_oe_o <= ~txsh[6];
            end
          end
          S_MACK: begin
            if (scl_rise_i) mack <= ~sda_s_i;
            if (scl_fall_i) begin
              if (mack && bidx == 2'd2) begin
                bidx     <= 2'd3;
                bcnt     <= '0;
                txsh     <= rval[BYTE_W-1:0];
                sda_oe_o <= ~rval[BYTE_W-1];
                st       <= S_TX;
              end else begin
                st <= S_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11
  oe_edge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_s_i));

  // R5
  wr_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o && !(issue_op_o inside {CMD_RD_WIPER, CMD_RD_DATA})) |-> $past(stop_i));

  // R8
  rd_on_instr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o && (issue_op_o inside {CMD_RD_WIPER, CMD_RD_DATA})) |-> $past(scl_rise_i));

  // R8
  oe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> (st == S_ACK || st == S_TX));

endmodule

// File: rtl/potctl_cmd_port.sv
module potctl_cmd_port
  import potctl_pkg::*;
#(
  parameter int unsigned VAL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  cmd_op_e          issue_op_i,
  input  logic [1:0]       issue_sel_i,
  input  logic [VAL_W-1:0] issue_data_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [2:0]       op_o,
  output logic [1:0]       sel_o,
  output logic [VAL_W-1:0] data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      op_o    <= '0;
      sel_o   <= '0;
      data_o  <= '0;
    end else if (issue_i) begin
      valid_o <= 1'b1;
      op_o    <= issue_op_i;
      sel_o   <= issue_sel_i;
      data_o  <= issue_data_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  // R10
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(op_o) && $stable(sel_o) && $stable(data_o)));

  // R3
  no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> !(valid_o && !ready_i));

endmodule

// File: rtl/potctl_twowire_slave.sv
module potctl_twowire_slave
  import potctl_pkg::*;
#(
  parameter int unsigned VAL_W       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       dev_addr_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             busy_i,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  output logic [2:0]       cmd_op_o,
  output logic [1:0]       cmd_sel_o,
  output logic [VAL_W-1:0] cmd_data_o,
  input  logic             rsp_valid_i,
  input  logic [VAL_W-1:0] rsp_data_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic issue;
  cmd_op_e issue_op;
  logic [1:0] issue_sel;
  logic [VAL_W-1:0] issue_data;
  logic hold;

  assign hold = busy_i | cmd_valid_o;

  potctl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  potctl_link #(.VAL_W(VAL_W)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop),
    .dev_addr_i(dev_addr_i), .hold_i(hold),
    .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
    .sda_oe_o(sda_oe_o), .issue_o(issue), .issue_op_o(issue_op),
    .issue_sel_o(issue_sel), .issue_data_o(issue_data)
  );

  potctl_cmd_port #(.VAL_W(VAL_W)) u_port (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .issue_op_i(issue_op),
    .issue_sel_i(issue_sel), .issue_data_i(issue_data), .ready_i(cmd_ready_i),
    .valid_o(cmd_valid_o), .op_o(cmd_op_o), .sel_o(cmd_sel_o), .data_o(cmd_data_o)
  );

endmodule

// File: tb/tb_potctl_twowire_slave.sv
module tb_potctl_twowire_slave;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 10;
  localparam logic [2:0] MY_ADDR = 3'b011;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic busy = 1'b0, cmd_ready = 1'b1;
  logic [2:0] dev_addr = MY_ADDR;
  logic rsp_valid = 1'b0;
  logic [9:0] rsp_data = '0;
  logic sda_oe, cmd_valid;
  logic [2:0] cmd_op;
  logic [1:0] cmd_sel;
  logic [9:0] cmd_data;
  wire sda_line = m_sda & ~sda_oe;

  int n_chk = 0, n_bad = 0, n_cmd = 0, oe_viol = 0, rsp_wait = 0;
  logic [2:0] last_op;
  logic [1:0] last_sel;
  logic [9:0] last_data, bank_val;
  logic prev_oe = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  potctl_twowire_slave dut (
    .clk(clk), .rst_n(rst_n), .dev_addr_i(dev_addr), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .busy_i(busy), .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_op_o(cmd_op), .cmd_sel_o(cmd_sel), .cmd_data_o(cmd_data),
    .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data)
  );

  // register bank model
  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (rsp_wait > 0) begin
      rsp_wait <= rsp_wait - 1;
      if (rsp_wait == 1) begin rsp_valid <= 1'b1; rsp_data <= bank_val; end
    end
    if (cmd_valid && cmd_ready) begin
      n_cmd <= n_cmd + 1;
      last_op <= cmd_op; last_sel <= cmd_sel; last_data <= cmd_data;
      if (cmd_op <= 3'd1) rsp_wait <= 2;
    end
  end

  // R11 monitor: oe may only change while the bus clock is low
  always @(negedge clk) begin
    if (sda_oe !== prev_oe && m_scl) oe_viol++;
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(QTR); m_scl = 1'b1; tick(QTR);
    m_sda = 1'b0; tick(QTR); m_scl = 1'b0; tick(QTR);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(QTR); m_scl = 1'b1; tick(QTR); m_sda = 1'b1; tick(QTR);
  endtask

  task automatic write_bit(input logic b);
    m_sda = b; tick(QTR); m_scl = 1'b1; tick(2*QTR); m_scl = 1'b0; tick(QTR);
  endtask

  task automatic read_bit(output logic b);
    m_sda = 1'b1; tick(QTR); m_scl = 1'b1; tick(QTR); b = sda_line;
    tick(QTR); m_scl = 1'b0; tick(QTR);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) write_bit(d[i]);
    read_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin read_bit(b); d[i] = b; end
    write_bit(~mack);
  endtask

  typedef struct packed {
    logic [7:0] instr;
    logic       rw;
    logic [9:0] val;
    logic       exp_ack;
    logic [2:0] exp_op;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{8'hA0, 1'b0, 10'h2A5, 1'b1, 3'd3},
    '{8'hC8, 1'b0, 10'h1FF, 1'b1, 3'd4},
    '{8'h80, 1'b1, 10'h3C3, 1'b1, 3'd0},
    '{8'hAC, 1'b1, 10'h001, 1'b1, 3'd1},
    '{8'hC4, 1'b1, 10'h000, 1'b1, 3'd2},
    '{8'hE0, 1'b0, 10'h000, 1'b1, 3'd5},
    '{8'h80, 1'b0, 10'h000, 1'b0, 3'd7},
    '{8'hE0, 1'b1, 10'h000, 1'b0, 3'd7},
    '{8'hB0, 1'b0, 10'h000, 1'b0, 3'd7},
    '{8'hCC, 1'b0, 10'h3FF, 1'b1, 3'd4}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic ack;
    logic [7:0] b8;
    int n0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // reset state (R10, R11)
    chk(sda_oe == 1'b0, "R11 reset oe", sda_oe, 0);
    chk(cmd_valid == 1'b0, "R10 reset valid", cmd_valid, 0);

    // table walk: R2 R4 R5 R7 R8 R10
    foreach (VECS[k]) begin
      vec_t v;
      bit data_ph;
      v = VECS[k];
      data_ph = v.exp_ack && (v.exp_op == 3'd0 || v.exp_op == 3'd1 || v.exp_op == 3'd3 || v.exp_op == 3'd4);
      n0 = n_cmd;
      bank_val = v.val;
      bus_start();
      send_byte({4'b0101, MY_ADDR, v.rw}, ack);
      chk(ack, "R2 address ack", ack, 1);
      send_byte(v.instr, ack);
      chk(ack == v.exp_ack, "R4 instruction ack", ack, v.exp_ack);
      if (data_ph) begin
        if (!v.rw) begin
          send_byte({6'b0, v.val[9:8]}, ack);
          chk(ack, "R5 data byte 1 ack", ack, 1);
          send_byte(v.val[7:0], ack);
          chk(ack, "R5 data byte 2 ack", ack, 1);
        end else begin
          recv_byte(b8, 1'b1);
          chk(b8 == {6'b0, v.val[9:8]}, "R8 read byte 1", b8, {6'b0, v.val[9:8]});
          recv_byte(b8, 1'b0);
          chk(b8 == v.val[7:0], "R8 read byte 2", b8, v.val[7:0]);
        end
      end
      bus_stop();
      tick(8);
      if (v.exp_ack) begin
        chk(n_cmd == n0 + 1, "R7 one command", n_cmd - n0, 1);
        chk(last_op == v.exp_op, "R10 op code", last_op, v.exp_op);
        chk(last_sel == v.instr[3:2], "R4 select", last_sel, v.instr[3:2]);
        if (!v.rw && data_ph)
          chk(last_data == v.val, "R5 write value", last_data, v.val);
      end else begin
        chk(n_cmd == n0, "R4 no command", n_cmd - n0, 0);
      end
    end

    // R1: byte without start is ignored
    send_byte({4'b0101, MY_ADDR, 1'b0}, ack);
    chk(!ack, "R1 no start no ack", ack, 0);
    bus_stop();

    // R2: pin mismatch and type mismatch
    bus_start();
    send_byte({4'b0101, 3'b101, 1'b0}, ack);
    chk(!ack, "R2 pin mismatch", ack, 0);
    bus_stop();
    bus_start();
    send_byte({4'b0111, MY_ADDR, 1'b0}, ack);
    chk(!ack, "R2 type mismatch", ack, 0);
    bus_stop();

    // R3: busy blocks address ack
    busy = 1'b1;
    bus_start();
    send_byte({4'b0101, MY_ADDR, 1'b1}, ack);
    chk(!ack, "R3 busy nack", ack, 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    send_byte({4'b0101, MY_ADDR, 1'b1}, ack);
    chk(ack, "R3 ack after busy", ack, 1);
    bus_stop();

    // R6: truncated write
    n0 = n_cmd;
    bus_start();
    send_byte({4'b0101, MY_ADDR, 1'b0}, ack);
    send_byte(8'hA0, ack);
    send_byte(8'h03, ack);
    bus_stop();
    tick(8);
    chk(n_cmd == n0, "R6 truncated write", n_cmd - n0, 0);

    // R6: complete write cut by repeated start
    bus_start();
    send_byte({4'b0101, MY_ADDR, 1'b0}, ack);
    send_byte(8'hC4, ack);
    send_byte(8'h01, ack);
    send_byte(8'h23, ack);
    bus_start();
    bus_stop();
    tick(8);
    chk(n_cmd == n0, "R6 restart cancels", n_cmd - n0, 0);

    // R9: master nack after first read byte
    bank_val = 10'h2F0;
    bus_start();
    send_byte({4'b0101, MY_ADDR, 1'b1}, ack);
    send_byte(8'h80, ack);
    recv_byte(b8, 1'b0);
    chk(b8 == 8'h02, "R9 first byte", b8, 8'h02);
    recv_byte(b8, 1'b0);
    chk(b8 == 8'hFF, "R9 line released", b8, 8'hFF);
    bus_stop();
    tick(8);

    // R10 / R3: back-pressure on the command port
    cmd_ready = 1'b0;
    n0 = n_cmd;
    bus_start();
    send_byte({4'b0101, MY_ADDR, 1'b0}, ack);
    send_byte(8'hA0, ack);
    send_byte(8'h01, ack);
    send_byte(8'h55, ack);
    bus_stop();
    tick(4);
    chk(cmd_valid == 1'b1, "R10 pending valid", cmd_valid, 1);
    tick(30);
    chk(cmd_valid == 1'b1 && cmd_data == 10'h155, "R10 held data", cmd_data, 10'h155);
    chk(cmd_op == 3'd3, "R10 held op", cmd_op, 3);
    bus_start();
    send_byte({4'b0101, MY_ADDR, 1'b0}, ack);
    chk(!ack, "R3 pending nack", ack, 0);
    bus_stop();
    cmd_ready = 1'b1;
    tick(3);
    chk(n_cmd == n0 + 1 && cmd_valid == 1'b0, "R10 accepted", n_cmd - n0, 1);

    chk(oe_viol == 0, "R11 oe changes with clock low", oe_viol, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule